// File: doc/BRIEF.md
# Audio AGC Gain Step Controller

This controller chooses the gain code of a programmable-gain audio amplifier from a measured envelope level. The envelope arrives as a signed number in 0.5 dB units. The gain code, also in 0.5 dB units, is the only output. The level the amplifier would produce is taken as envelope plus current gain. That level is compared with a limit and, in the compressing modes, with a target that follows a 2:1 curve above a knee.

The gain moves one half-decibel step at a time. Three interval timers, counted in periodic ticks, pace the moves. The attack interval paces reductions. The hold interval delays the start of recovery. The release interval paces increases. A 2-bit mode selects one of four behaviours: bypass at the fixed gain, limiting alone, limiting with compression, or limiting with compression and a noise gate.

The envelope input is a valid/ready stream. The controller keeps `env_ready` high at all times and never applies back-pressure. A sample is accepted on every clock edge where `env_valid` is high. The last accepted sample stays in use until the next one arrives. Mode, tick and gain are plain control pins.

Top module: `agc_gain_stepper`

## Requirements
- R1: Except on a mode change or reset, the gain code changes by at most one code (0.5 dB) per clock cycle.
- R2: Mode encoding is 00 bypass, 01 limiter, 10 limiter+compression, 11 limiter+compression+gate. In mode 00 the gain is the fixed value FIX_GAIN (default 12, i.e. 6 dB), whatever the envelope. Reset also sets the gain to FIX_GAIN.
- R3: The gain stays within 0 and a ceiling. The ceiling is FIX_GAIN in mode 01 and MAX_GAIN (default 60, i.e. 30 dB) in modes 10 and 11. A reduction requested at 0 leaves the gain at 0.
- R4: The level is "over" when it exceeds the target. When the level is over and no attack interval is running, the gain drops one code on the clock edge after the over condition first appears, and an attack interval starts.
- R5: While the level stays over and the attack interval is running, the gain is held. When ATK_TICKS ticks have elapsed with the level still over, the gain drops one more code and all timers restart.
- R6: The level is "under" when it is below target minus WINDOW and the gain is below the ceiling. Continuous under for HOLD_TICKS ticks, then REL_TICKS more ticks, raises the gain by one code and restarts all timers. Any cycle that is not under clears the hold and release progress. Timers advance only on cycles where tick is high.
- R7: When the level lies between target minus WINDOW and the target, inclusive, the gain does not change.
- R8: In mode 01 the target is LIMIT_LVL (default 18, i.e. 9 dBV). In modes 10 and 11 the target is the smaller of LIMIT_LVL and the compression curve. The curve is env+MAX_GAIN at or below KNEE_LVL, and KNEE_LVL+MAX_GAIN+floor((env-KNEE_LVL)/2) above it.
- R9: In mode 11, an envelope below GATE_LVL (default -68, about 20 mV) freezes the gain and all timers.
- R10: A change of mode reloads the gain to FIX_GAIN on the next clock edge and clears all timers.
- R11: Envelope samples are taken only when env_valid is high, and env_ready is always 1. The compared level is the last accepted envelope plus the gain code, in two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle pulse marking a timer period |
| mode | input | 2 | Function select (00 bypass, 01 limiter, 10 compress, 11 compress+gate) |
| env_valid | input | 1 | Envelope sample valid |
| env_level | input | EW | Signed envelope level, 0.5 dB units |
| env_ready | output | 1 | Always 1; the controller never stalls the envelope stream |
| gain_code | output | clog2(MAX_GAIN+1) | Gain in 0.5 dB steps |

## Verification
The bench builds the controller with the default levels and a short timer set: ATK_TICKS=3, HOLD_TICKS=2, REL_TICKS=4, with tick held high. With these values a full climb from 6 dB to the ceiling takes a few hundred cycles. That makes it feasible to sweep the envelope over -100..38 in every active mode and compare the settled gain with the arithmetically derived target. The short intervals also let directed sequences count the exact edge of the first cut, the attack repeat, the hold-then-release rise, and the restart after an interrupted recovery.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic [1:0] {
    AGC_OFF   = 2'b00,
    AGC_LIMIT = 2'b01,
    AGC_COMP  = 2'b10,
    AGC_GATE  = 2'b11
  } agc_mode_e;

  localparam int T_ATK  = 0;
  localparam int T_HOLD = 1;
  localparam int T_REL  = 2;
  localparam int N_TMR  = 3;
endpackage

// File: rtl/agc_tick_timer.sv
module agc_tick_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic tick,
  output logic expire
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt;

  assign expire = en && tick && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (en && tick) begin
      cnt <= expire ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/agc_level_eval.sv
module agc_level_eval
  import agc_pkg::*;
#(
  parameter int EW   = 8,
  parameter int GW   = 6,
  parameter int LW   = 10,
  parameter int FIX  = 12,
  parameter int MAX  = 60,
  parameter int LIM  = 18,
  parameter int KNEE = -60,
  parameter int GATE = -68,
  parameter int WIN  = 1
) (
  input  logic signed [EW-1:0] env_q,
  input  logic [GW-1:0]        gain,
  input  logic [1:0]           mode,
  output logic                 over,
  output logic                 under,
  output logic                 gated
);
  localparam logic signed [LW-1:0] LIM_L  = LW'(LIM);
  localparam logic signed [LW-1:0] KNEE_L = LW'(KNEE);
  localparam logic signed [LW-1:0] GATE_L = LW'(GATE);
  localparam logic signed [LW-1:0] WIN_L  = LW'(WIN);
  localparam logic signed [LW-1:0] FIX_L  = LW'(FIX);
  localparam logic signed [LW-1:0] MAX_L  = LW'(MAX);

  logic signed [LW-1:0] env_x, gain_x, lvl, above, curve, tgt, ceil;

  always_comb begin
    env_x  = LW'(env_q);
    gain_x = $signed({{(LW-GW){1'b0}}, gain});
    lvl    = env_x + gain_x;
    above  = env_x - KNEE_L;
    curve  = (env_x <= KNEE_L) ? (env_x + MAX_L) : (KNEE_L + MAX_L + (above >>> 1));
    if (mode == AGC_LIMIT) begin
      tgt  = LIM_L;
      ceil = FIX_L;
    end else begin
      tgt  = (curve < LIM_L) ? curve : LIM_L;
      ceil = MAX_L;
    end
    over  = lvl > tgt;
    under = (lvl < (tgt - WIN_L)) && (gain_x < ceil);
    gated = (mode == AGC_GATE) && (env_x < GATE_L);
  end
endmodule

// File: rtl/agc_gain_core.sv
module agc_gain_core
  import agc_pkg::*;
#(
  parameter int GW  = 6,
  parameter int FIX = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             over,
  input  logic             under,
  input  logic             gated,
  input  logic [N_TMR-1:0] expire,
  output logic [N_TMR-1:0] tmr_clr,
  output logic [N_TMR-1:0] tmr_en,
  output logic             reload,
  output logic [GW-1:0]    gain
);
  logic [1:0] mode_q;
  logic atk_run, hold_done;
  logic active, flush, first_cut, atk_cut, rise, cut, restart, drop_back;

  always_comb begin
    reload    = (mode != mode_q);
    flush     = reload || (mode == AGC_OFF);
    active    = !flush && !gated;
    first_cut = active && over && !atk_run;
    atk_cut   = active && over && expire[T_ATK];
    rise      = active && under && expire[T_REL];
    cut       = first_cut || atk_cut;
    restart   = cut || rise;
    drop_back = active && !under;

    tmr_en[T_ATK]   = active && atk_run;
    tmr_en[T_HOLD]  = active && under && !hold_done;
    tmr_en[T_REL]   = active && under && hold_done;
    tmr_clr[T_ATK]  = flush || restart;
    tmr_clr[T_HOLD] = flush || restart || drop_back;
    tmr_clr[T_REL]  = flush || restart || drop_back;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gain      <= GW'(FIX);
      mode_q    <= AGC_OFF;
      atk_run   <= 1'b0;
      hold_done <= 1'b0;
    end else begin
      mode_q <= mode;
      if (flush) begin
        gain      <= GW'(FIX);
        atk_run   <= 1'b0;
        hold_done <= 1'b0;
      end else if (active) begin
        if (cut && (gain != '0)) gain <= gain - 1'b1;
        else if (rise)           gain <= gain + 1'b1;

        if (first_cut)                   atk_run <= 1'b1;
        else if (rise)                   atk_run <= 1'b0;
        else if (expire[T_ATK] && !over) atk_run <= 1'b0;

        if (restart || !under)   hold_done <= 1'b0;
        else if (expire[T_HOLD]) hold_done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/agc_gain_stepper.sv
module agc_gain_stepper
  import agc_pkg::*;
#(
  parameter int EW         = 8,
  parameter int FIX_GAIN   = 12,
  parameter int MAX_GAIN   = 60,
  parameter int LIMIT_LVL  = 18,
  parameter int KNEE_LVL   = -60,
  parameter int GATE_LVL   = -68,
  parameter int WINDOW     = 1,
  parameter int ATK_TICKS  = 64,
  parameter int HOLD_TICKS = 16,
  parameter int REL_TICKS  = 18100,
  localparam int GW        = $clog2(MAX_GAIN + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic [1:0]           mode,
  input  logic                 env_valid,
  input  logic signed [EW-1:0] env_level,
  output logic                 env_ready,
  output logic [GW-1:0]        gain_code
);
  localparam int LW = ((EW > GW) ? EW : GW) + 2;
  localparam int TLIM [N_TMR] = '{ATK_TICKS, HOLD_TICKS, REL_TICKS};

  logic signed [EW-1:0] env_q;
  logic lvl_over, lvl_under, gated, reload;
  logic [N_TMR-1:0] expire, tmr_clr, tmr_en;

  assign env_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (rst)            env_q <= {1'b1, {(EW-1){1'b0}}};
    else if (env_valid) env_q <= env_level;
  end

  agc_level_eval #(
    .EW(EW), .GW(GW), .LW(LW), .FIX(FIX_GAIN), .MAX(MAX_GAIN),
    .LIM(LIMIT_LVL), .KNEE(KNEE_LVL), .GATE(GATE_LVL), .WIN(WINDOW)
  ) u_eval (
    .env_q(env_q), .gain(gain_code), .mode(mode),
    .over(lvl_over), .under(lvl_under), .gated(gated)
  );

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    agc_tick_timer #(.LIMIT(TLIM[i])) u_tmr (
      .clk(clk), .rst(rst), .clr(tmr_clr[i]), .en(tmr_en[i]),
      .tick(tick), .expire(expire[i])
    );
  end

  agc_gain_core #(.GW(GW), .FIX(FIX_GAIN)) u_core (
    .clk(clk), .rst(rst), .mode(mode), .over(lvl_over), .under(lvl_under),
    .gated(gated), .expire(expire), .tmr_clr(tmr_clr), .tmr_en(tmr_en),
    .reload(reload), .gain(gain_code)
  );
endmodule

// File: rtl/agc_gain_stepper_chk.sv
module agc_gain_stepper_chk #(
  parameter int GW  = 6,
  parameter int FIX = 12,
  parameter int MAX = 60
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    mode,
  input logic [GW-1:0] gain_code,
  input logic          reload,
  input logic          gated,
  input logic          over,
  input logic          under
);
  localparam logic [GW-1:0] FIX_C = GW'(FIX);
  localparam logic [GW-1:0] MAX_C = GW'(MAX);

  assert_single_step_R1: assert property (@(posedge clk) disable iff (rst)
    !reload |=> ((gain_code == $past(gain_code)) ||
                 ({1'b0, gain_code} == {1'b0, $past(gain_code)} + 1'b1) ||
                 ({1'b0, gain_code} + 1'b1 == {1'b0, $past(gain_code)})));

  assert_bypass_fixed_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> (gain_code == FIX_C));

  assert_gain_ceiling_R3: assert property (@(posedge clk) disable iff (rst)
    gain_code <= MAX_C);

  assert_limiter_ceiling_R3: assert property (@(posedge clk) disable iff (rst)
    ((mode == 2'b01) && !reload) |=> (gain_code <= FIX_C));

  assert_window_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!over && !under && !reload && (mode != 2'b00)) |=> $stable(gain_code));

  assert_gate_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    (gated && !reload) |=> $stable(gain_code));

  assert_mode_reload_R10: assert property (@(posedge clk) disable iff (rst)
    reload |=> (gain_code == FIX_C));
endmodule

bind agc_gain_stepper agc_gain_stepper_chk #(
  .GW(GW), .FIX(FIX_GAIN), .MAX(MAX_GAIN)
) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .gain_code(gain_code), .reload(reload),
  .gated(gated), .over(lvl_over), .under(lvl_under)
);

// File: tb/sim_agc_gain_stepper.sv
module sim_agc_gain_stepper;
  localparam int CLK_PERIOD = 10;
  localparam int GW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic [1:0] mode = 2'b00;
  logic env_valid = 1'b0;
  logic signed [7:0] env_level = '0;
  logic env_ready;
  logic [GW-1:0] gain_code;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit jump_seen = 1'b0;
  int prev_gain = 12;

  always #(CLK_PERIOD/2) clk = ~clk;

  agc_gain_stepper #(
    .EW(8), .FIX_GAIN(12), .MAX_GAIN(60), .LIMIT_LVL(18), .KNEE_LVL(-60),
    .GATE_LVL(-68), .WINDOW(1), .ATK_TICKS(3), .HOLD_TICKS(2), .REL_TICKS(4)
  ) u0 (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .env_valid(env_valid),
    .env_level(env_level), .env_ready(env_ready), .gain_code(gain_code)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", tag, got, exp);
    end
  endtask

  function automatic int settled(input int m, input int e);
    int tgt, ceil, curve, g;
    if (m == 0) return 12;
    if (m == 3 && e < -68) return 12;
    if (m == 1) begin
      tgt = 18; ceil = 12;
    end else begin
      curve = (e <= -60) ? e + 60 : ((e + 60) >>> 1);
      tgt = (curve < 18) ? curve : 18;
      ceil = 60;
    end
    g = 12;
    if (e + g > tgt) begin
      g = tgt - e;
      if (g < 0) g = 0;
    end else if (e + g < tgt - 1) begin
      g = tgt - 1 - e;
      if (g > ceil) g = ceil;
    end
    return g;
  endfunction

  // R1 monitor: any jump larger than one code must be a reload to the fixed value
  always @(negedge clk) begin
    if (!rst) begin
      if (((int'(gain_code) - prev_gain) > 1 || (prev_gain - int'(gain_code)) > 1) &&
          gain_code != 6'd12)
        jump_seen = 1'b1;
      prev_gain = int'(gain_code);
    end
  end

  task automatic enter(input int m, input int e);
    mode = 2'b00; env_level = 8'(e); env_valid = 1'b1;
    step(3);
    mode = 2'(m);
  endtask

  initial begin
    step(4);
    rst = 1'b0;
    step(1);
    check("R2 reset gain", int'(gain_code), 12);
    check("R11 ready high", int'(env_ready), 1);

    // R2 bypass ignores a loud envelope
    enter(0, 38);
    step(50);
    check("R2 bypass", int'(gain_code), 12);

    // sweep of settled gain in each active mode
    for (int m = 1; m <= 3; m++) begin
      for (int e = -100; e <= 38; e += 2) begin
        enter(m, e);
        step(320);
        if (m == 1)
          check("R3 limiter settle", int'(gain_code), settled(m, e));
        else if (m == 3 && e < -68)
          check("R9 gate freeze", int'(gain_code), settled(m, e));
        else
          check("R8 compress settle", int'(gain_code), settled(m, e));
      end
    end

    // R4 first cut and R5 attack pacing
    enter(1, 6);
    step(20);
    check("R7 at limit no change", int'(gain_code), 12);
    env_level = 8'sd10;
    step(1); check("R4 before cut", int'(gain_code), 12);
    step(1); check("R4 immediate cut", int'(gain_code), 11);
    step(2); check("R5 held during attack", int'(gain_code), 11);
    step(1); check("R5 attack cut", int'(gain_code), 10);
    step(3); check("R5 second attack cut", int'(gain_code), 9);
    step(30); check("R5 settle at limit", int'(gain_code), 8);

    // R6 hold then release
    env_level = 8'sd0;
    step(6); check("R6 before release", int'(gain_code), 8);
    step(1); check("R6 release rise", int'(gain_code), 9);
    step(2);
    env_level = 8'sd9;
    step(1);
    env_level = 8'sd0;
    step(6); check("R6 restart delays rise", int'(gain_code), 9);
    step(1); check("R6 rise after restart", int'(gain_code), 10);

    // R7 window, R11 ignored samples, R10 reload
    enter(2, 0);
    step(320);
    check("R8 settle", int'(gain_code), 17);
    step(200);
    check("R7 window steady", int'(gain_code), 17);
    env_valid = 1'b0; env_level = 8'sd40;
    step(100);
    check("R11 invalid sample ignored", int'(gain_code), 17);
    mode = 2'b01;
    step(1);
    check("R10 reload on mode change", int'(gain_code), 12);

    check("R1 single steps", int'(jump_seen), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog got 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule